// File: doc/BRIEF.md
# Eight-Class Egress Scheduler with Priority Remapping

This block decides which frame descriptor leaves one output port next. Each arriving descriptor carries a 4-bit switch priority and a frame length in bytes. A writable lookup table turns the priority into one of eight traffic classes. The descriptor is then appended to that class's own FIFO. Frame data is held elsewhere; only the descriptors pass through here.

On the dequeue side a single arbiter offers one descriptor at a time, with its class and length, and removes it when the consumer raises ready. A mode register selects the arbitration rule. In strict mode the highest-numbered class that holds work always wins. In deficit weighted round-robin mode a pointer visits the classes in turn. On each visit a class adds its programmed byte quantum to its deficit. It sends head frames while they fit within that deficit, and it keeps any unused credit while it still has frames waiting.

Top module: `egress_sched`

## Requirements
- R1: After reset, switch priority p maps to class p/2 (integer division), so priority 5 lands in class 2 and priority 15 in class 7; `deq_cls` reports the class and `deq_len` the length of the offered descriptor.
- R2: Any priority can be written to any class through the map port. An enqueue in the same cycle as a map write still uses the old entry. Enqueues from the next cycle on use the new entry.
- R3: Within one class, descriptors leave in the order they were accepted, each with its original length.
- R4: In strict mode (mode value 0), `deq_valid` is high whenever any class holds a descriptor, and `deq_cls` is the highest-numbered non-empty class.
- R5: In round-robin mode (mode value 1), the classes are visited in ascending order, wrapping from 7 to 0. Empty classes are passed over. Each visit adds the class quantum to its deficit and serves head frames whose length does not exceed the deficit, subtracting each length.
- R6: A head frame longer than the current deficit ends the visit; the leftover deficit is kept for that class's next visit.
- R7: A class's deficit returns to zero at the moment its queue becomes empty, so no credit is carried into a later burst.
- R8: Each class holds at most DEPTH descriptors (default 4). An enqueue to a full class is rejected: `enq_drop` is high in that same cycle, the descriptor is not stored, and `drop_count` increases by one on the next edge.
- R9: The mode resets to strict, and a mode write changes the arbitration rule from the following cycle.
- R10: In round-robin mode, while the consumer holds `deq_ready` low, the offered class stays the same and the scheduler state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Descriptor enqueue strobe |
| enq_prio | input | 4 | Switch priority of the descriptor |
| enq_len | input | 14 | Frame length in bytes |
| enq_drop | output | 1 | Enqueue rejected because the target class is full |
| drop_count | output | 16 | Saturating count of rejected enqueues |
| deq_valid | output | 1 | A descriptor is offered |
| deq_ready | input | 1 | Consumer takes the offered descriptor |
| deq_cls | output | 3 | Class of the offered descriptor |
| deq_len | output | 14 | Length of the offered descriptor |
| map_we | input | 1 | Priority map write strobe |
| map_prio | input | 4 | Priority entry to write |
| map_cls | input | 3 | Class written to that entry |
| quant_we | input | 1 | Quantum write strobe |
| quant_cls | input | 3 | Class whose quantum is written |
| quant_bytes | input | 16 | Quantum in bytes |
| mode_we | input | 1 | Mode write strobe |
| mode_dwrr | input | 1 | Mode written: 0 strict, 1 round-robin |

## Verification
An enqueue and a dequeue can hit the same class FIFO in the same cycle. This matters in two cases. When that class is full, the enqueue must still be dropped, because the full test uses the count before the pop. When the class holds exactly one descriptor, the queue does not become empty and its deficit must survive. A long strict-mode run drives enqueues and a randomly toggling ready together, with traffic squeezed into few classes so these collisions happen often. A per-cycle occupancy model predicts every drop pulse, every offered class and every popped length. Round-robin bursts are drained under random backpressure and compared, frame by frame, against a visit-order model.

// File: rtl/egs_pkg.sv
`timescale 1ns/1ps
package egs_pkg;

    typedef enum logic {
        SCH_STRICT = 1'b0,
        SCH_DWRR   = 1'b1
    } sch_mode_e;

    // Reset mapping: priorities spread evenly over the classes.
    function automatic int unsigned cls_for_prio(int unsigned prio, int unsigned n_prio,
                                                 int unsigned n_cls);
        return (prio * n_cls) / n_prio;
    endfunction

endpackage

// File: rtl/egs_class_fifo.sv
`timescale 1ns/1ps
module egs_class_fifo #(
    parameter int DEPTH = 4,
    parameter int LEN_W = 14,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop,
    output logic [LEN_W-1:0] head_len,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [LEN_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = wrap_inc(st_q.wr);
        if (pop)  st_d.rd = wrap_inc(st_q.rd);
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= push_len;
    end

    assign head_len = mem_q[st_q.rd];
    assign count    = st_q.cnt;
    assign full     = (st_q.cnt == CNT_W'(DEPTH));
    assign empty    = (st_q.cnt == '0);

    // R8: the parent never pushes into a full queue
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R3: the scheduler never pops an empty queue
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/egs_prio_map.sv
`timescale 1ns/1ps
module egs_prio_map #(
    parameter int NUM_PRIO = 16,
    parameter int NUM_CLS  = 8,
    localparam int PRIO_W  = $clog2(NUM_PRIO),
    localparam int CLS_W   = $clog2(NUM_CLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic [CLS_W-1:0]  wr_cls,
    input  logic [PRIO_W-1:0] lk_prio,
    output logic [CLS_W-1:0]  lk_cls
);

    typedef struct packed {
        logic [NUM_PRIO-1:0][CLS_W-1:0] tbl;
    } map_st_t;

    map_st_t st_d, st_q;

    function automatic map_st_t map_reset();
        map_st_t r;
        for (int p = 0; p < NUM_PRIO; p++)
            r.tbl[p] = CLS_W'(egs_pkg::cls_for_prio(p, NUM_PRIO, NUM_CLS));
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.tbl[wr_prio] = wr_cls;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= map_reset();
        else        st_q <= st_d;
    end

    assign lk_cls = st_q.tbl[lk_prio];

    // R2: a written entry holds the written class on the next cycle
    p_map_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.tbl[$past(wr_prio)] == $past(wr_cls));

endmodule

// File: rtl/egs_arbiter.sv
`timescale 1ns/1ps
module egs_arbiter #(
    parameter int NUM_CLS     = 8,
    parameter int LEN_W       = 14,
    parameter int QUANT_W     = 16,
    parameter int DEF_QUANTUM = 1518,
    localparam int CLS_W      = $clog2(NUM_CLS),
    localparam int MAX_W      = (LEN_W > QUANT_W) ? LEN_W : QUANT_W,
    localparam int DEF_W      = MAX_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           mode_we,
    input  logic                           mode_val,
    input  logic                           q_we,
    input  logic [CLS_W-1:0]               q_idx,
    input  logic [QUANT_W-1:0]             q_val,
    input  logic [NUM_CLS-1:0]             nonempty,
    input  logic [NUM_CLS-1:0]             last,
    input  logic [NUM_CLS-1:0][LEN_W-1:0]  head_len,
    input  logic                           ready,
    output logic                           grant_valid,
    output logic [CLS_W-1:0]               grant_cls
);
    import egs_pkg::*;

    typedef struct packed {
        sch_mode_e                         mode;
        logic [CLS_W-1:0]                  ptr;
        logic                              visited;
        logic [NUM_CLS-1:0][DEF_W-1:0]     deficit;
        logic [NUM_CLS-1:0][QUANT_W-1:0]   quant;
    } arb_st_t;

    arb_st_t          st_d, st_q;
    logic [CLS_W-1:0] hi_cls;
    logic [CLS_W-1:0] ptr_nxt;
    logic [DEF_W-1:0] eff;
    logic             dwrr_ok;
    logic             take;

    function automatic arb_st_t arb_reset();
        arb_st_t r;
        r.mode    = SCH_STRICT;
        r.ptr     = '0;
        r.visited = 1'b0;
        r.deficit = '0;
        for (int c = 0; c < NUM_CLS; c++) r.quant[c] = QUANT_W'(DEF_QUANTUM);
        return r;
    endfunction

    always_comb begin
        hi_cls = '0;
        for (int c = 0; c < NUM_CLS; c++)
            if (nonempty[c]) hi_cls = CLS_W'(c);

        ptr_nxt = (st_q.ptr == CLS_W'(NUM_CLS - 1)) ? '0 : st_q.ptr + 1'b1;
        eff     = st_q.deficit[st_q.ptr]
                + (st_q.visited ? '0 : DEF_W'(st_q.quant[st_q.ptr]));
        dwrr_ok = nonempty[st_q.ptr] && (DEF_W'(head_len[st_q.ptr]) <= eff);

        if (st_q.mode == SCH_STRICT) begin
            grant_valid = |nonempty;
            grant_cls   = hi_cls;
        end else begin
            grant_valid = dwrr_ok;
            grant_cls   = st_q.ptr;
        end
        take = grant_valid && ready;

        st_d = st_q;
        if (mode_we) st_d.mode = sch_mode_e'(mode_val);
        if (q_we)    st_d.quant[q_idx] = q_val;

        // credit never outlives the backlog, in either mode
        if (take && last[grant_cls]) st_d.deficit[grant_cls] = '0;

        if (st_q.mode == SCH_DWRR && ready && (|nonempty)) begin
            if (dwrr_ok) begin
                if (last[st_q.ptr]) begin
                    st_d.deficit[st_q.ptr] = '0;
                    st_d.ptr               = ptr_nxt;
                    st_d.visited           = 1'b0;
                end else begin
                    st_d.deficit[st_q.ptr] = eff - DEF_W'(head_len[st_q.ptr]);
                    st_d.visited           = 1'b1;
                end
            end else begin
                st_d.deficit[st_q.ptr] = nonempty[st_q.ptr] ? eff : '0;
                st_d.ptr               = ptr_nxt;
                st_d.visited           = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= arb_reset();
        else        st_q <= st_d;
    end

    // R3: a grant always points at a queue holding work
    p_grant_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> nonempty[grant_cls]);
    // R4: strict mode offers the top non-empty class and never idles with work
    p_strict_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SCH_STRICT && grant_valid) |-> ((nonempty >> grant_cls) == NUM_CLS'(1)));
    p_strict_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SCH_STRICT && (|nonempty)) |-> grant_valid);
    // R7: a queue draining to empty leaves zero deficit
    p_deficit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last[grant_cls]) |=> st_q.deficit[$past(grant_cls)] == '0);
    // R10: a stalled round-robin offer is held
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SCH_DWRR && grant_valid && !ready && !mode_we && !q_we)
            |=> (grant_valid && $stable(grant_cls)));

endmodule

// File: rtl/egress_sched.sv
`timescale 1ns/1ps
module egress_sched #(
    parameter int NUM_PRIO    = 16,
    parameter int NUM_CLS     = 8,
    parameter int DEPTH       = 4,
    parameter int LEN_W       = 14,
    parameter int QUANT_W     = 16,
    parameter int DEF_QUANTUM = 1518,
    parameter int DROP_W      = 16,
    localparam int PRIO_W     = $clog2(NUM_PRIO),
    localparam int CLS_W      = $clog2(NUM_CLS),
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic [PRIO_W-1:0]  enq_prio,
    input  logic [LEN_W-1:0]   enq_len,
    output logic               enq_drop,
    output logic [DROP_W-1:0]  drop_count,
    output logic               deq_valid,
    input  logic               deq_ready,
    output logic [CLS_W-1:0]   deq_cls,
    output logic [LEN_W-1:0]   deq_len,
    input  logic               map_we,
    input  logic [PRIO_W-1:0]  map_prio,
    input  logic [CLS_W-1:0]   map_cls,
    input  logic               quant_we,
    input  logic [CLS_W-1:0]   quant_cls,
    input  logic [QUANT_W-1:0] quant_bytes,
    input  logic               mode_we,
    input  logic               mode_dwrr
);

    typedef struct packed {
        logic [DROP_W-1:0] drops;
    } top_st_t;

    top_st_t                        st_d, st_q;
    logic [CLS_W-1:0]               tgt_cls;
    logic [NUM_CLS-1:0]             push, pop, full, empty, last;
    logic [NUM_CLS-1:0][LEN_W-1:0]  head_len;
    logic [NUM_CLS-1:0][CNT_W-1:0]  count;

    egs_prio_map #(.NUM_PRIO(NUM_PRIO), .NUM_CLS(NUM_CLS)) map_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_we), .wr_prio(map_prio), .wr_cls(map_cls),
        .lk_prio(enq_prio), .lk_cls(tgt_cls)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign push[c] = enq_valid && (tgt_cls == CLS_W'(c)) && !full[c];
        assign pop[c]  = deq_valid && deq_ready && (deq_cls == CLS_W'(c));
        assign last[c] = (count[c] == CNT_W'(1)) && !push[c];

        egs_class_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) fifo_i (
            .clk(clk), .rst_n(rst_n),
            .push(push[c]), .push_len(enq_len), .pop(pop[c]),
            .head_len(head_len[c]), .count(count[c]),
            .full(full[c]), .empty(empty[c])
        );
    end

    egs_arbiter #(
        .NUM_CLS(NUM_CLS), .LEN_W(LEN_W), .QUANT_W(QUANT_W), .DEF_QUANTUM(DEF_QUANTUM)
    ) arb_i (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_val(mode_dwrr),
        .q_we(quant_we), .q_idx(quant_cls), .q_val(quant_bytes),
        .nonempty(~empty), .last(last), .head_len(head_len),
        .ready(deq_ready),
        .grant_valid(deq_valid), .grant_cls(deq_cls)
    );

    assign enq_drop = enq_valid && full[tgt_cls];
    assign deq_len  = head_len[deq_cls];

    always_comb begin
        st_d = st_q;
        if (enq_drop && (st_q.drops != '1)) st_d.drops = st_q.drops + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drop_count = st_q.drops;

    // R8: each rejected enqueue advances the counter by one
    p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_drop && drop_count != '1) |=> drop_count == $past(drop_count) + 1'b1);
    // R8: nothing is stored when the drop pulse fires
    p_drop_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enq_drop |-> (push == '0));

endmodule

// File: tb/egress_sched_tb_top.sv
`timescale 1ns/1ps
module egress_sched_tb_top;

    localparam int NP = 16, NC = 8, DEPTH = 4, LEN_W = 14, QW = 16, DQ = 1518;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enq_valid = 0, enq_drop, deq_valid, deq_ready = 0;
    logic [3:0]  enq_prio = 0, map_prio = 0;
    logic [13:0] enq_len = 0, deq_len;
    logic [15:0] drop_count, quant_bytes = 0;
    logic [2:0]  deq_cls, map_cls = 0, quant_cls = 0;
    logic map_we = 0, quant_we = 0, mode_we = 0, mode_dwrr = 0;

    always #4 clk = ~clk;

    egress_sched dut_i (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_prio(enq_prio),
        .enq_len(enq_len), .enq_drop(enq_drop), .drop_count(drop_count),
        .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_cls(deq_cls), .deq_len(deq_len),
        .map_we(map_we), .map_prio(map_prio), .map_cls(map_cls),
        .quant_we(quant_we), .quant_cls(quant_cls), .quant_bytes(quant_bytes),
        .mode_we(mode_we), .mode_dwrr(mode_dwrr)
    );

    // stimulus staging
    bit s_enq_v, s_ready, s_mw, s_qw, s_mode_we, s_mode;
    int s_prio, s_len, s_mprio, s_mcls, s_qcls, s_qval;

    // reference model
    int m_map[NP];
    int m_quant[NC];
    int m_def[NC];
    int m_ptr, m_mode, m_drops;
    int mq[NC][$];
    int exp_seq[$];

    int n_cmp = 0, n_err = 0;
    bit last_pop, prev_stall;
    int last_cls, prev_cls;

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_hi();
        int h = -1;
        for (int c = 0; c < NC; c++) if (mq[c].size() > 0) h = c;
        return h;
    endfunction

    task automatic tick();
        int ecls, hi, pc;
        bit edrop, popd;
        @(negedge clk);
        enq_valid = s_enq_v; enq_prio = 4'(s_prio); enq_len = 14'(s_len);
        deq_ready = s_ready;
        map_we = s_mw; map_prio = 4'(s_mprio); map_cls = 3'(s_mcls);
        quant_we = s_qw; quant_cls = 3'(s_qcls); quant_bytes = 16'(s_qval);
        mode_we = s_mode_we; mode_dwrr = s_mode;
        #2;
        ecls  = m_map[s_prio];
        edrop = s_enq_v && (mq[ecls].size() == DEPTH);
        if (s_enq_v) chk(enq_drop == edrop, "R8 drop pulse", enq_drop, edrop);
        if (m_mode == 0) begin
            hi = model_hi();
            chk(deq_valid == (hi >= 0), "R4 valid", deq_valid, hi >= 0);
            if (hi >= 0) chk(deq_cls == 3'(hi), "R4 class", deq_cls, hi);
        end
        if (m_mode == 1 && prev_stall)
            chk(deq_valid && deq_cls == 3'(prev_cls), "R10 hold", deq_cls, prev_cls);
        prev_stall = deq_valid && !s_ready && m_mode == 1 && !s_qw && !s_mode_we;
        prev_cls   = deq_cls;
        popd = deq_valid && s_ready;
        pc   = deq_cls;
        if (popd) begin
            if (mq[pc].size() == 0) chk(1'b0, "R3 pop of empty class", pc, -1);
            else chk(deq_len == 14'(mq[pc][0]), "R3 length order", deq_len, mq[pc][0]);
        end
        last_pop = popd; last_cls = pc;
        @(posedge clk); #1;
        if (popd && mq[pc].size() > 0) begin
            void'(mq[pc].pop_front());
            if (mq[pc].size() == 0) m_def[pc] = 0;
        end
        if (s_enq_v) begin
            if (edrop) m_drops++;
            else mq[ecls].push_back(s_len);
        end
        if (s_mw) m_map[s_mprio] = s_mcls;
        if (s_qw) m_quant[s_qcls] = s_qval;
        if (s_mode_we) m_mode = s_mode;
        s_enq_v = 0; s_mw = 0; s_qw = 0; s_mode_we = 0;
    endtask

    task automatic enq(int prio, int len);
        s_enq_v = 1; s_prio = prio; s_len = len; tick();
    endtask

    task automatic set_quant(int c, int v);
        s_qw = 1; s_qcls = c; s_qval = v; tick();
    endtask

    task automatic set_mode(int m);
        s_mode_we = 1; s_mode = m[0]; tick();
    endtask

    // round-robin visit-order model; commits the resulting pointer and deficits
    task automatic dwrr_plan();
        int cq[NC][$];
        int total = 0, eff, c;
        for (int i = 0; i < NC; i++) begin cq[i] = mq[i]; total += cq[i].size(); end
        exp_seq.delete();
        while (total > 0) begin
            c = m_ptr;
            if (cq[c].size() == 0) m_def[c] = 0;
            else begin
                eff = m_def[c] + m_quant[c];
                while (cq[c].size() > 0 && cq[c][0] <= eff) begin
                    eff -= cq[c][0];
                    exp_seq.push_back(c);
                    void'(cq[c].pop_front());
                    total--;
                end
                m_def[c] = (cq[c].size() == 0) ? 0 : eff;
            end
            m_ptr = (m_ptr + 1) % NC;
        end
    endtask

    task automatic drain_dwrr(string tag);
        int guard = 0, e;
        dwrr_plan();
        while (exp_seq.size() > 0 && guard < 4000) begin
            s_ready = ($urandom % 4) != 0;
            tick();
            if (last_pop) begin
                e = exp_seq.pop_front();
                chk(last_cls == e, tag, last_cls, e);
            end
            guard++;
        end
        if (exp_seq.size() > 0) chk(1'b0, tag, exp_seq.size(), 0);
        s_ready = 0; prev_stall = 0;
    endtask

    task automatic drain_strict();
        int guard = 0;
        s_ready = 1;
        while (model_hi() >= 0 && guard < 2000) begin tick(); guard++; end
        chk(model_hi() < 0, "R4 strict drain", model_hi(), -1);
        s_ready = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int p = 0; p < NP; p++) m_map[p] = p / 2;
        for (int c = 0; c < NC; c++) begin m_quant[c] = DQ; m_def[c] = 0; end
        m_ptr = 0; m_mode = 0; m_drops = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(deq_valid == 1'b0, "R4 reset idle", deq_valid, 0);
        chk(drop_count == 16'd0, "R8 reset count", drop_count, 0);
        chk(enq_drop == 1'b0, "R8 reset drop", enq_drop, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 default map
        enq(5, 100);
        chk(deq_valid && deq_cls == 3'd2, "R1 prio5 class", deq_cls, 2);
        chk(deq_len == 14'd100, "R1 length", deq_len, 100);
        enq(15, 200);
        chk(deq_cls == 3'd7, "R1 prio15 class", deq_cls, 7);
        drain_strict();

        // R2 map write beside an enqueue
        s_mw = 1; s_mprio = 3; s_mcls = 6;
        enq(3, 300);
        enq(3, 400);
        chk(deq_cls == 3'd6 && deq_len == 14'd400, "R2 new entry", deq_cls, 6);
        chk(mq[1].size() == 1, "R2 old entry used", mq[1].size(), 1);
        drain_strict();

        // R8 overflow of one class
        for (int i = 0; i < DEPTH + 2; i++) enq(0, 64 + i);
        chk(drop_count == 16'd2, "R8 count", drop_count, 2);
        drain_strict();

        // R9 mode switch: strict offers 7, round-robin starts at pointer 0
        enq(0, 100);
        enq(14, 100);
        chk(deq_cls == 3'd7, "R9 strict before", deq_cls, 7);
        set_mode(1);
        chk(deq_valid && deq_cls == 3'd0, "R9 dwrr after", deq_cls, 0);
        drain_dwrr("R9 order");

        // R5 / R6 quantum and carried deficit
        set_quant(0, 500);
        set_quant(1, 1500);
        for (int i = 0; i < 3; i++) enq(0, 400);
        enq(2, 1000);
        enq(2, 1000);
        drain_dwrr("R6 order");

        // R7 deficit cleared when a class empties
        set_quant(0, 1000);
        set_quant(7, 100);
        enq(0, 600);
        drain_dwrr("R7 first burst");
        enq(0, 1200);
        enq(15, 100);
        enq(15, 100);
        drain_dwrr("R7 order");

        // R5 random bursts
        for (int r = 0; r < 12; r++) begin
            for (int c = 0; c < NC; c++) set_quant(c, 200 + $urandom % 1800);
            for (int k = 0; k < 3; k++) begin
                s_mw = 1; s_mprio = $urandom % NP; s_mcls = $urandom % NC; tick();
            end
            for (int k = 0; k < 8 + $urandom % 24; k++) enq($urandom % NP, 64 + $urandom % 1455);
            drain_dwrr("R5 order");
        end

        // collisions of enqueue and dequeue, strict mode
        set_mode(0);
        for (int k = 0; k < 3000; k++) begin
            s_enq_v = ($urandom % 3) != 0;
            s_prio  = ($urandom % 2) ? ($urandom % 4) : ($urandom % NP);
            s_len   = 64 + $urandom % 1455;
            s_ready = ($urandom % 3) != 0;
            if ($urandom % 50 == 0) begin
                s_mw = 1; s_mprio = $urandom % NP; s_mcls = $urandom % NC;
            end
            tick();
        end
        drain_strict();
        chk(drop_count == 16'(m_drops), "R8 final count", drop_count, m_drops);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule